// File: doc/BRIEF.md
# IOMMU Page Translation Unit

This block turns DMA bus addresses into physical addresses through a single-level table of 64-bit translation entries held on chip. The page number of a request (the bus address shifted right by the page shift) selects an entry. The entry gives the physical page and, in its two least significant bits, the access rights. So one table read answers both where the page lives and whether it may be read or written.

Every lookup returns a response one clock after the request. The response carries the page-aligned bus address, the physical page address, the offset mask, the permission code, a fault flag for the requested direction, and the complete physical address. Software or a loader fills the table through a one-entry-per-cycle write port. A single-cycle clear input invalidates every entry at once, which makes every page fault until it is written again. Page size (as a shift), entry count and address widths are parameters.

Top module: `iommu_xlat`

## Requirements
- R1: A lookup presented with `req_valid` high at a clock edge produces `resp_valid` high after exactly that edge, for one cycle per request. The response reflects page number `req_addr >> PAGE_SHIFT`. With no request, `resp_valid` is low.
- R2: A page number at or above `NUM_ENTRIES` gives permission 0, a zero `resp_page`, a zero `resp_iova` and an all-ones `resp_mask`.
- R3: For an in-range page, `resp_page` is the entry with its low `PAGE_SHIFT` bits cleared, and `resp_iova` is the bus address with its low `PAGE_SHIFT` bits cleared.
- R4: For an in-range page, `resp_mask` equals 2^PAGE_SHIFT − 1.
- R5: `resp_perm` is entry bits [1:0]: 0 no access, 1 read only, 2 write only, 3 read and write.
- R6: `resp_fault` is high when a write meets permission 0 or 1, or when a read meets permission 0 or 2. Otherwise it is low.
- R7: `resp_phys` equals `resp_page` ORed with the zero-extended bus address ANDed with `resp_mask`.
- R8: After reset every entry reads as zero, so every lookup faults, and `resp_valid` is low while reset is held.
- R9: A cycle with `clr` high zeroes every entry. A table write in the same cycle is dropped.
- R10: With `wr_en` high, `wr_entry` is stored at page `wr_page`. A `wr_page` at or above `NUM_ENTRIES` changes no entry.
- R11: A lookup and a write to the same page at the same edge return the entry as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Invalidate all table entries this cycle |
| wr_en | input | 1 | Table write strobe |
| wr_page | input | BA_W-PAGE_SHIFT | Page number to write |
| wr_entry | input | PA_W | Entry value (page address, permission in bits 1:0) |
| req_valid | input | 1 | Lookup request |
| req_addr | input | BA_W | Bus address to translate |
| req_is_write | input | 1 | Requested direction: 1 write, 0 read |
| resp_valid | output | 1 | Response valid, one cycle after request |
| resp_iova | output | BA_W | Page-aligned bus address |
| resp_page | output | PA_W | Physical page address |
| resp_mask | output | PA_W | In-page offset mask |
| resp_perm | output | 2 | Permission code |
| resp_fault | output | 1 | Requested access not permitted |
| resp_phys | output | PA_W | Full physical address |

## Verification
The bench drives two copies of the block from the same stimulus. Both use a 32-bit bus, 64-bit entries and a 4 KiB page. One copy has 48 entries, so its range check is a magnitude compare. The other has 16 entries, so it uses the power-of-two high-bit test. A write to page 20 is then in range for the first copy and out of range for the second. This shows that an out-of-range write cannot wrap onto entry 4. Pages 16 to 63 give out-of-range lookups on one or both copies, and the all-ones address checks the top of the bus space.

// File: rtl/iommu_xlat_pkg.sv
package iommu_xlat_pkg;

   typedef enum logic [1:0] {
      PERM_NONE  = 2'd0,
      PERM_READ  = 2'd1,
      PERM_WRITE = 2'd2,
      PERM_BOTH  = 2'd3
   } perm_e;

   function automatic logic access_ok(input perm_e perm, input logic is_write);
      logic ok;
      unique case (perm)
         PERM_NONE:  ok = 1'b0;
         PERM_READ:  ok = ~is_write;
         PERM_WRITE: ok = is_write;
         default:    ok = 1'b1;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/iommu_xlat_range.sv
module iommu_xlat_range #(
   parameter int PN_W        = 20,
   parameter int NUM_ENTRIES = 64
) (
   input  logic [PN_W-1:0] page_num,
   output logic            in_range
);
   localparam bit IS_POW2 = (NUM_ENTRIES & (NUM_ENTRIES - 1)) == 0;
   localparam int LOG2N   = $clog2(NUM_ENTRIES);

   generate
      if (IS_POW2 && LOG2N >= PN_W) begin : g_full
         assign in_range = 1'b1;
      end else if (IS_POW2) begin : g_pow2
         assign in_range = ~|(page_num >> LOG2N);
      end else begin : g_cmp
         assign in_range = page_num < PN_W'(NUM_ENTRIES);
      end
   endgenerate
endmodule

// File: rtl/iommu_xlat_table.sv
module iommu_xlat_table #(
   parameter int PA_W        = 64,
   parameter int NUM_ENTRIES = 64,
   parameter int IDX_W       = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic             wr_ok,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PA_W-1:0]  wr_data,
   input  logic             rd_en,
   input  logic             rd_ok,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PA_W-1:0]  rd_data
);
   logic [PA_W-1:0]        mem [0:NUM_ENTRIES-1];
   logic [NUM_ENTRIES-1:0] live;
   logic                   do_wr;

   assign do_wr = wr_en && wr_ok && !clr;

   // Entry payload: plain RAM, no reset.
   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_idx] <= wr_data;
   end

   // One live flag per entry; the clear and the reset act on these only.
   generate
      for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    live[e] <= 1'b0;
            else if (clr)                                  live[e] <= 1'b0;
            else if (do_wr && wr_idx == IDX_W'(e))         live[e] <= 1'b1;
         end
      end
   endgenerate

   // Read-first synchronous read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_en)  rd_data <= (rd_ok && live[rd_idx]) ? mem[rd_idx] : '0;
   end
endmodule

// File: rtl/iommu_xlat_perm.sv
module iommu_xlat_perm
   import iommu_xlat_pkg::*;
(
   input  logic [1:0] perm,
   input  logic       is_write,
   output logic       fault
);
   assign fault = ~access_ok(perm_e'(perm), is_write);
endmodule

// File: rtl/iommu_xlat.sv
module iommu_xlat #(
   parameter int BA_W        = 32,
   parameter int PA_W        = 64,
   parameter int PAGE_SHIFT  = 12,
   parameter int NUM_ENTRIES = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       wr_en,
   input  logic [BA_W-PAGE_SHIFT-1:0] wr_page,
   input  logic [PA_W-1:0]            wr_entry,
   input  logic                       req_valid,
   input  logic [BA_W-1:0]            req_addr,
   input  logic                       req_is_write,
   output logic                       resp_valid,
   output logic [BA_W-1:0]            resp_iova,
   output logic [PA_W-1:0]            resp_page,
   output logic [PA_W-1:0]            resp_mask,
   output logic [1:0]                 resp_perm,
   output logic                       resp_fault,
   output logic [PA_W-1:0]            resp_phys
);
   localparam int PN_W  = BA_W - PAGE_SHIFT;
   localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
   localparam logic [PA_W-1:0] OFF_MASK =
      {{(PA_W-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};
   localparam logic [PA_W-1:0] PG_MASK  = ~OFF_MASK;
   localparam logic [BA_W-1:0] BA_PG_MASK =
      {{PN_W{1'b1}}, {PAGE_SHIFT{1'b0}}};

   // Elaboration-time parameter checks.
   generate
      if (PAGE_SHIFT < 2 || PAGE_SHIFT >= BA_W) begin : g_bad_shift
         $error("iommu_xlat: PAGE_SHIFT must lie in [2, BA_W-1]");
      end
      if (PA_W < BA_W) begin : g_bad_pa
         $error("iommu_xlat: PA_W must be at least BA_W");
      end
      if (NUM_ENTRIES < 1) begin : g_bad_n
         $error("iommu_xlat: NUM_ENTRIES must be positive");
      end
      if (IDX_W > PN_W) begin : g_bad_depth
         $error("iommu_xlat: NUM_ENTRIES exceeds the page-number space");
      end
   endgenerate

   logic [PN_W-1:0] req_pn;
   logic            rd_in_range, wr_in_range;
   logic [PA_W-1:0] rd_entry;

   assign req_pn = req_addr[BA_W-1:PAGE_SHIFT];

   iommu_xlat_range #(.PN_W(PN_W), .NUM_ENTRIES(NUM_ENTRIES)) u_rd_range (
      .page_num (req_pn),
      .in_range (rd_in_range)
   );

   iommu_xlat_range #(.PN_W(PN_W), .NUM_ENTRIES(NUM_ENTRIES)) u_wr_range (
      .page_num (wr_page),
      .in_range (wr_in_range)
   );

   iommu_xlat_table #(.PA_W(PA_W), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr_en   (wr_en),
      .wr_ok   (wr_in_range),
      .wr_idx  (wr_page[IDX_W-1:0]),
      .wr_data (wr_entry),
      .rd_en   (req_valid),
      .rd_ok   (rd_in_range),
      .rd_idx  (req_pn[IDX_W-1:0]),
      .rd_data (rd_entry)
   );

   // Request stage registers, aligned with the table read.
   logic            vld_q, wr_q, hit_q;
   logic [BA_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         wr_q   <= 1'b0;
         hit_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         vld_q <= req_valid;
         if (req_valid) begin
            wr_q   <= req_is_write;
            hit_q  <= rd_in_range;
            addr_q <= req_addr;
         end
      end
   end

   // Response formation.
   logic [1:0] perm_w;

   assign perm_w     = hit_q ? rd_entry[1:0] : 2'd0;
   assign resp_valid = vld_q;
   assign resp_perm  = perm_w;
   assign resp_page  = hit_q ? (rd_entry & PG_MASK) : '0;
   assign resp_mask  = hit_q ? OFF_MASK : '1;
   assign resp_iova  = hit_q ? (addr_q & BA_PG_MASK) : '0;
   assign resp_phys  = resp_page | (PA_W'(addr_q) & resp_mask);

   iommu_xlat_perm u_perm (
      .perm     (perm_w),
      .is_write (wr_q),
      .fault    (resp_fault)
   );
endmodule

// File: rtl/iommu_xlat_chk.sv
module iommu_xlat_chk #(
   parameter int BA_W        = 32,
   parameter int PA_W        = 64,
   parameter int PAGE_SHIFT  = 12,
   parameter int NUM_ENTRIES = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            clr,
   input logic            req_valid,
   input logic [BA_W-1:0] req_addr,
   input logic            req_is_write,
   input logic            resp_valid,
   input logic [BA_W-1:0] resp_iova,
   input logic [PA_W-1:0] resp_page,
   input logic [PA_W-1:0] resp_mask,
   input logic [1:0]      resp_perm,
   input logic            resp_fault,
   input logic [PA_W-1:0] resp_phys
);
   localparam logic [PA_W-1:0] PAGE_BYTES_M1 = PA_W'((64'd1 << PAGE_SHIFT) - 64'd1);

   // R1
   p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);
   p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid);

   // R2
   p_out_of_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ((req_addr >> PAGE_SHIFT) >= BA_W'(NUM_ENTRIES)))
      |=> (resp_perm == 2'd0 && resp_page == '0 && resp_iova == '0 && (&resp_mask)));

   // R4
   p_mask_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_perm != 2'd0) |-> resp_mask == PAGE_BYTES_M1);

   // R6
   p_fault_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> resp_fault ==
         ($past(req_is_write) ? !resp_perm[1] : !resp_perm[0]));

   // R7
   p_phys_compose_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> resp_phys == (resp_page | (PA_W'($past(req_addr)) & resp_mask)));

   // R9
   p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr ##1 req_valid) |=> (resp_perm == 2'd0 && resp_page == '0));
endmodule

bind iommu_xlat iommu_xlat_chk #(
   .BA_W(BA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_ENTRIES(NUM_ENTRIES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clr          (clr),
   .req_valid    (req_valid),
   .req_addr     (req_addr),
   .req_is_write (req_is_write),
   .resp_valid   (resp_valid),
   .resp_iova    (resp_iova),
   .resp_page    (resp_page),
   .resp_mask    (resp_mask),
   .resp_perm    (resp_perm),
   .resp_fault   (resp_fault),
   .resp_phys    (resp_phys)
);

// File: tb/tb_iommu_xlat.sv
`timescale 1ns/1ps
module tb_iommu_xlat;
   localparam int BA_W = 32, PA_W = 64, PS = 12, PN_W = BA_W - PS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            clr = 0, wr_en = 0, req_valid = 0, req_is_write = 0;
   logic [PN_W-1:0] wr_page = '0;
   logic [PA_W-1:0] wr_entry = '0;
   logic [BA_W-1:0] req_addr = '0;

   logic            o_valid [2];
   logic [BA_W-1:0] o_iova  [2];
   logic [PA_W-1:0] o_page  [2];
   logic [PA_W-1:0] o_mask  [2];
   logic [1:0]      o_perm  [2];
   logic            o_fault [2];
   logic [PA_W-1:0] o_phys  [2];

   iommu_xlat #(.BA_W(BA_W), .PA_W(PA_W), .PAGE_SHIFT(PS), .NUM_ENTRIES(48)) dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_page(wr_page),
      .wr_entry(wr_entry), .req_valid(req_valid), .req_addr(req_addr),
      .req_is_write(req_is_write), .resp_valid(o_valid[0]), .resp_iova(o_iova[0]),
      .resp_page(o_page[0]), .resp_mask(o_mask[0]), .resp_perm(o_perm[0]),
      .resp_fault(o_fault[0]), .resp_phys(o_phys[0]));

   iommu_xlat #(.BA_W(BA_W), .PA_W(PA_W), .PAGE_SHIFT(PS), .NUM_ENTRIES(16)) dut_p2 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_page(wr_page),
      .wr_entry(wr_entry), .req_valid(req_valid), .req_addr(req_addr),
      .req_is_write(req_is_write), .resp_valid(o_valid[1]), .resp_iova(o_iova[1]),
      .resp_page(o_page[1]), .resp_mask(o_mask[1]), .resp_perm(o_perm[1]),
      .resp_fault(o_fault[1]), .resp_phys(o_phys[1]));

   // Behavioural reference: one table per copy.
   int              nents [2] = '{48, 16};
   logic [PA_W-1:0] mdl [2][64];
   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(input string tag, input string ctx, input int inst,
                      input logic [PA_W-1:0] act, input logic [PA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s [%s] copy%0d: actual %h expected %h", tag, ctx, inst, act, exp);
      end
   endtask

   task automatic step(input string ctx, input logic v, input logic [BA_W-1:0] a,
                       input logic w, input logic we, input logic [PN_W-1:0] wp,
                       input logic [PA_W-1:0] wd, input logic c);
      logic [PA_W-1:0] e_page[2], e_mask[2], e_phys[2];
      logic [BA_W-1:0] e_iova[2];
      logic [1:0]      e_perm[2];
      logic            e_fault[2];
      bit              e_hit[2];
      req_valid = v; req_addr = a; req_is_write = w;
      wr_en = we; wr_page = wp; wr_entry = wd; clr = c;
      for (int i = 0; i < 2; i++) begin
         int pn = int'(a >> PS);
         logic [PA_W-1:0] ent;
         e_hit[i] = pn < nents[i];
         ent = e_hit[i] ? mdl[i][pn] : '0;
         e_page[i] = e_hit[i] ? (ent & ~64'hFFF) : '0;
         e_mask[i] = e_hit[i] ? 64'hFFF : '1;
         e_iova[i] = e_hit[i] ? (a & ~32'hFFF) : '0;
         e_perm[i] = e_hit[i] ? ent[1:0] : 2'd0;
         e_fault[i] = w ? !e_perm[i][1] : !e_perm[i][0];
         e_phys[i] = e_page[i] | ({32'd0, a} & e_mask[i]);
      end
      @(posedge clk);
      for (int i = 0; i < 2; i++) begin
         if (c) begin
            for (int k = 0; k < 64; k++) mdl[i][k] = '0;
         end else if (we && int'(wp) < nents[i]) begin
            mdl[i][int'(wp)] = wd;
         end
      end
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         chk("R1", ctx, i, 64'(o_valid[i]), 64'(v));
         if (v) begin
            chk(e_hit[i] ? "R3" : "R2", ctx, i, o_page[i], e_page[i]);
            chk(e_hit[i] ? "R3" : "R2", ctx, i, 64'(o_iova[i]), 64'(e_iova[i]));
            chk(e_hit[i] ? "R4" : "R2", ctx, i, o_mask[i], e_mask[i]);
            chk("R5", ctx, i, 64'(o_perm[i]), 64'(e_perm[i]));
            chk("R6", ctx, i, 64'(o_fault[i]), 64'(e_fault[i]));
            chk("R7", ctx, i, o_phys[i], e_phys[i]);
         end
      end
      req_valid = 0; wr_en = 0; clr = 0;
   endtask

   function automatic logic [BA_W-1:0] pa(input int pn, input int off);
      return BA_W'(pn) << PS | BA_W'(off);
   endfunction

   initial begin
      for (int i = 0; i < 2; i++)
         for (int k = 0; k < 64; k++) mdl[i][k] = '0;
      repeat (3) @(negedge clk);
      // R8: no response while reset is held
      chk("R8", "reset", 0, 64'(o_valid[0]), 64'd0);
      chk("R8", "reset", 1, 64'(o_valid[1]), 64'd0);
      rst_n = 1;
      @(negedge clk);
      // R8: fresh table faults everywhere
      step("R8 empty", 1, pa(0, 16), 0, 0, '0, '0, 0);
      step("R8 empty", 1, pa(5, 8), 1, 0, '0, '0, 0);
      chk("R8", "empty fault", 0, 64'(o_fault[0]), 64'd1);
      // R10: programme entries with all permission codes
      step("R10 wr", 0, '0, 0, 1, PN_W'(3), 64'h0000_0001_2345_6001, 0);
      step("R10 wr", 0, '0, 0, 1, PN_W'(4), 64'h0000_00AB_CDEF_1002, 0);
      step("R10 wr", 0, '0, 0, 1, PN_W'(5), 64'hFFFF_FFFF_FFFF_F003, 0);
      step("R10 wr", 0, '0, 0, 1, PN_W'(6), 64'h0000_0000_7777_7000, 0);
      step("R10 wr", 0, '0, 0, 1, PN_W'(47), 64'h0000_0002_0000_0003, 0);
      // R5/R6: each permission against read and write
      for (int p = 3; p <= 6; p++) begin
         step("R5 R6 rd", 1, pa(p, 12'hABC), 0, 0, '0, '0, 0);
         step("R5 R6 wr", 1, pa(p, 12'h004), 1, 0, '0, '0, 0);
      end
      chk("R6", "wo read", 0, 64'(o_fault[0]), 64'd1);
      // R2: out-of-range pages for one or both copies
      step("R2 p47", 1, pa(47, 12'h123), 0, 0, '0, '0, 0);
      step("R2 p48", 1, pa(48, 12'h010), 0, 0, '0, '0, 0);
      step("R2 top", 1, 32'hFFFF_FFFF, 1, 0, '0, '0, 0);
      chk("R2", "top mask", 0, o_mask[0], '1);
      // R10: page 20 stored in copy0, must not wrap to entry 4 in copy1
      step("R10 oob", 0, '0, 0, 1, PN_W'(20), 64'h0000_0000_5555_5003, 0);
      step("R10 oob", 1, pa(4, 0), 0, 0, '0, '0, 0);
      chk("R10", "no wrap", 1, 64'(o_perm[1]), 64'd2);
      step("R10 oob", 1, pa(20, 0), 0, 0, '0, '0, 0);
      // R11: same-edge write and lookup returns old entry
      step("R11 same", 1, pa(7, 0), 0, 1, PN_W'(7), 64'h0000_0000_0808_0003, 0);
      chk("R11", "old value", 0, 64'(o_perm[0]), 64'd0);
      step("R11 after", 1, pa(7, 0), 0, 0, '0, '0, 0);
      chk("R11", "new value", 0, 64'(o_perm[0]), 64'd3);
      // R9: clear beats a same-cycle write
      step("R9 clr", 0, '0, 0, 1, PN_W'(9), 64'h0000_0000_0909_0003, 1);
      step("R9 after", 1, pa(9, 0), 0, 0, '0, '0, 0);
      chk("R9", "write dropped", 0, 64'(o_perm[0]), 64'd0);
      step("R9 after", 1, pa(3, 0), 0, 0, '0, '0, 0);
      chk("R9", "entry cleared", 0, o_page[0], 64'd0);
      // Mixed traffic against the reference model
      for (int n = 0; n < 600; n++) begin
         logic [BA_W-1:0] a;
         a = pa(int'($urandom_range(63)), int'($urandom_range(4095)));
         step("mix R1 R3 R7", $urandom_range(3) != 0, a, $urandom_range(1) == 1,
              $urandom_range(1) == 1, PN_W'($urandom_range(63)),
              {$urandom, $urandom}, $urandom_range(60) == 0);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule